// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is an up-counting timer that turns two compare values into a pulse-width-modulated output. One value sets the period and the other sets the active width. Software writes each value into a holding register. A shadow buffer copies the holding register only at the period boundary. This lets the waveform be changed while the timer runs without ever producing a torn period: the new values take effect with the next period.

The counter runs only while the run enable is high. It advances on system-clock cycles where the count strobe is high. When the timer is idle, the counter rests at all ones, so the first strobe after enabling wraps it to zero and starts the first period. The block has four outputs:
- the PWM level;
- a toggle output that flips once per period;
- a one-cycle pulse at each period restart;
- a one-cycle pulse when the count reaches the width value.

Top module: `bcpwm_timer`

## Requirements
- R1: After a synchronous reset, all four outputs are low. Period holding register and buffer reset to all ones. Width holding register and buffer reset to zero.
- R2: While run_en is low, the counter rests at all ones. The first tick after run_en rises moves it to zero and starts a period, and raises no period pulse.
- R3: The counter changes only on clock cycles where run_en and tick are both high.
- R4: On a tick where the count equals the period buffer, the counter goes to zero. per_irq is then high in the following clock cycle, the first cycle that shows count zero.
- R5: A value written while running reaches its buffer only at a period-match restart. Until then, the waveform of the current period is unchanged.
- R6: With tick held high, successive per_irq pulses are (period value + 1) clock cycles apart.
- R7: pwm_out is high while the running count is below the width buffer, which gives (width value) active ticks per period. duty_irq is high in the first clock cycle that the count equals the width buffer after a step.
- R8: A width value of 0 keeps pwm_out low. A width value greater than the period value keeps pwm_out high while running.
- R9: tog_out inverts on every period-match restart and is low while idle.
- R10: While run_en is low, pwm_out and tog_out are low and both buffers track their holding registers, so the first period uses the latest written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer run enable |
| tick | input | 1 | Count strobe; counter advances when high |
| per_wr | input | 1 | Write strobe for the period holding register |
| per_wdata | input | CNT_W | Period value to write |
| duty_wr | input | 1 | Write strobe for the width holding register |
| duty_wdata | input | CNT_W | Width value to write |
| pwm_out | output | 1 | PWM level |
| tog_out | output | 1 | Half-rate toggle output |
| per_irq | output | 1 | Period restart pulse |
| duty_irq | output | 1 | Width match pulse |

## Verification
The bench goes after a period value of zero, where the counter restarts on every tick. A design that detected the match one count late would stretch the period and drift per_irq. Width values of zero and above the period are covered too. Off-by-one compare logic would leak a one-tick glitch or drop the last active tick. Writes are placed in the middle of a period to catch designs that load the buffer immediately, which would show as a changed pulse width within the same period. The first tick after enable is also probed, because a design that treated the wrap from all ones as a period match would fire per_irq and reload early.

// File: rtl/bcpwm_pkg.sv
package bcpwm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // counter events of one clock cycle
    typedef struct packed {
        logic step;   // counter moves this cycle
        logic start;  // wrap from rest value
        logic clear;  // period-match restart
    } cnt_evt_t;

    function automatic logic is_match(input logic [31:0] a, input logic [31:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/bcpwm_regs.sv
module bcpwm_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         per_wr,
    input  logic [W-1:0] per_wdata,
    input  logic         duty_wr,
    input  logic [W-1:0] duty_wdata,
    output logic [W-1:0] per_buf,
    output logic [W-1:0] duty_buf
);
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] per_hold;
    logic [W-1:0] duty_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_hold  <= ONES;
            duty_hold <= '0;
            per_buf   <= ONES;
            duty_buf  <= '0;
        end else begin
            if (per_wr)  per_hold  <= per_wdata;
            if (duty_wr) duty_hold <= duty_wdata;
            if (load) begin
                per_buf  <= per_hold;
                duty_buf <= duty_hold;
            end
        end
    end

    // R5
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(per_buf) && $stable(duty_buf)));

endmodule

// File: rtl/bcpwm_counter.sv
module bcpwm_counter
    import bcpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         tick,
    input  logic [W-1:0] per_buf,
    output logic [W-1:0] cnt,
    output logic         running,
    output cnt_evt_t     evt
);
    localparam logic [W-1:0] ONES = '1;

    run_st_e st;

    always_comb begin
        evt.step  = run_en && tick;
        evt.start = evt.step && (st == ST_IDLE);
        evt.clear = evt.step && (st == ST_RUN) && is_match(32'(cnt), 32'(per_buf));
    end

    assign running = (st == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= ONES;
            st  <= ST_IDLE;
        end else if (evt.step) begin
            if (evt.start) begin
                cnt <= '0;
                st  <= ST_RUN;
            end else if (evt.clear) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !tick) |=> $stable(cnt));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= per_buf));

    // R2
    idle_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (cnt == ONES && !running));

endmodule

// File: rtl/bcpwm_outgen.sv
module bcpwm_outgen
    import bcpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] cnt,
    input  logic         running,
    input  logic [W-1:0] duty_buf,
    input  cnt_evt_t     evt,
    output logic         pwm_out,
    output logic         tog_out,
    output logic         per_irq,
    output logic         duty_irq
);
    logic step_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_out <= 1'b0;
            per_irq <= 1'b0;
            step_d  <= 1'b0;
        end else begin
            per_irq <= evt.clear;
            step_d  <= evt.step;
            if (!run_en)        tog_out <= 1'b0;
            else if (evt.clear) tog_out <= ~tog_out;
        end
    end

    assign pwm_out  = running && (cnt < duty_buf);
    assign duty_irq = step_d && running && is_match(32'(cnt), 32'(duty_buf));

    // R7
    duty_irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        duty_irq |-> !pwm_out);

    // R4
    per_irq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        per_irq |-> (running && cnt == '0));

    // R10
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!pwm_out && !tog_out));

endmodule

// File: rtl/bcpwm_timer.sv
module bcpwm_timer
    import bcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic             pwm_out,
    output logic             tog_out,
    output logic             per_irq,
    output logic             duty_irq
);
    logic [CNT_W-1:0] per_buf;
    logic [CNT_W-1:0] duty_buf;
    logic [CNT_W-1:0] cnt;
    logic             running;
    cnt_evt_t         evt;
    logic             load;

    assign load = !run_en || evt.clear;

    bcpwm_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .load(load),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .per_buf(per_buf), .duty_buf(duty_buf)
    );

    bcpwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .per_buf(per_buf), .cnt(cnt), .running(running), .evt(evt)
    );

    bcpwm_outgen #(.W(CNT_W)) u_out (
        .clk(clk), .rst(rst), .run_en(run_en), .cnt(cnt),
        .running(running), .duty_buf(duty_buf), .evt(evt),
        .pwm_out(pwm_out), .tog_out(tog_out),
        .per_irq(per_irq), .duty_irq(duty_irq)
    );

    // R2
    start_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !per_irq);

endmodule

// File: tb/bcpwm_timer_bench.sv
module bcpwm_timer_bench;
    localparam int W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0, tick = 1'b0, per_wr = 1'b0, duty_wr = 1'b0;
    logic [W-1:0] per_wdata = '0, duty_wdata = '0;
    logic pwm_out, tog_out, per_irq, duty_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcpwm_timer #(.CNT_W(W)) u_bcpwm_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .pwm_out(pwm_out), .tog_out(tog_out),
        .per_irq(per_irq), .duty_irq(duty_irq)
    );

    // reference model built from the requirements
    logic [W-1:0] m_preg, m_dreg, m_pbuf, m_dbuf, m_cnt;
    logic m_run, m_tog, m_pirq, m_dirq;

    always @(posedge clk) begin
        if (rst) begin
            m_preg <= ONES; m_dreg <= '0; m_pbuf <= ONES; m_dbuf <= '0;
            m_cnt <= ONES; m_run <= 1'b0; m_tog <= 1'b0;
            m_pirq <= 1'b0; m_dirq <= 1'b0;
        end else begin
            if (per_wr)  m_preg <= per_wdata;
            if (duty_wr) m_dreg <= duty_wdata;
            m_pirq <= 1'b0;
            m_dirq <= 1'b0;
            if (!run_en) begin
                m_cnt <= ONES; m_run <= 1'b0; m_tog <= 1'b0;
                m_pbuf <= m_preg; m_dbuf <= m_dreg;
            end else if (tick) begin
                if (!m_run) begin
                    m_cnt <= '0; m_run <= 1'b1;
                    m_dirq <= (m_dbuf == '0);
                end else if (m_cnt == m_pbuf) begin
                    m_cnt <= '0; m_pbuf <= m_preg; m_dbuf <= m_dreg;
                    m_tog <= ~m_tog; m_pirq <= 1'b1;
                    m_dirq <= (m_dreg == '0);
                end else begin
                    m_cnt <= m_cnt + 1'b1;
                    m_dirq <= ((m_cnt + 1'b1) == m_dbuf);
                end
            end
        end
    end

    function automatic logic exp_pwm(logic run, logic [W-1:0] c, logic [W-1:0] d);
        return run && (c < d);
    endfunction

    task automatic chk(input logic act, input logic expv, input string req);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, expv);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(pwm_out,  exp_pwm(m_run, m_cnt, m_dbuf), "R7/R8 pwm_out");
            chk(per_irq,  m_pirq, "R4 per_irq");
            chk(duty_irq, m_dirq, "R7 duty_irq");
            chk(tog_out,  m_tog,  "R9 tog_out");
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_both(input logic [W-1:0] p, input logic [W-1:0] d);
        @(negedge clk);
        per_wr = 1'b1; per_wdata = p; duty_wr = 1'b1; duty_wdata = d;
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0;
    endtask

    // measure one period with tick held high: spacing and active width
    task automatic measure(input int p, input int d, input string tag);
        int hi;
        int guard;
        hi = 0;
        guard = 0;
        while (per_irq !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
        for (int i = 0; i <= p; i++) begin
            if (pwm_out === 1'b1) hi++;
            @(negedge clk);
        end
        chk(per_irq, 1'b1, {"R6 period spacing ", tag});
        chk(hi == ((d > p) ? p + 1 : d), 1'b1, {"R7/R8 active width ", tag});
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        cyc(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk(pwm_out | tog_out | per_irq | duty_irq, 1'b0, "R1 reset outputs");

        // R2 start from rest, R6/R7 basic period
        wr_both(16'd4, 16'd2);
        @(negedge clk); run_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        chk(per_irq, 1'b0, "R2 no period pulse on start");
        chk(pwm_out, 1'b1, "R2 active after wrap");
        measure(4, 2, "p4 d2");
        measure(4, 2, "p4 d2 again");

        // R5 mid-period write: current period unchanged
        while (per_irq !== 1'b1) @(negedge clk);
        per_wr = 1'b1; per_wdata = 16'd7; duty_wr = 1'b1; duty_wdata = 16'd5;
        @(negedge clk); per_wr = 1'b0; duty_wr = 1'b0;
        begin
            int hi;
            hi = 1;
            for (int i = 0; i < 4; i++) begin
                if (pwm_out === 1'b1) hi++;
                @(negedge clk);
            end
            chk(per_irq, 1'b1, "R5 old period kept");
            chk(hi == 2, 1'b1, "R5 old width kept");
        end
        measure(7, 5, "R5 new values");

        // R8 width zero and width above period
        wr_both(16'd3, 16'd0);
        measure(3, 0, "R8 d0");
        measure(3, 0, "R8 d0 b");
        wr_both(16'd3, 16'd9);
        measure(3, 9, "R8 d>p");
        measure(3, 9, "R8 d>p b");

        // period zero: restart each tick
        wr_both(16'd0, 16'd1);
        measure(0, 1, "p0");
        measure(0, 1, "p0 b");

        // R10 disable loads buffers directly, R3 hold without tick
        @(negedge clk); run_en = 1'b0;
        @(negedge clk);
        chk(pwm_out | tog_out, 1'b0, "R10 idle outputs");
        wr_both(16'd5, 16'd3);
        cyc(2);
        @(negedge clk); run_en = 1'b1; tick = 1'b0;
        cyc(4);
        chk(pwm_out, 1'b0, "R3 no step without tick");
        tick = 1'b1;
        measure(5, 3, "R10 first period");

        // constrained random mix, checked cycle by cycle against the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick   = ($urandom % 3) != 0;
            run_en = ($urandom % 200) != 0;
            per_wr = ($urandom % 40) == 0;
            per_wdata = W'($urandom % 12);
            duty_wr = ($urandom % 30) == 0;
            duty_wdata = W'($urandom % 14);
        end
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0;
        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule